// File: doc/BRIEF.md
# Cascadable Display Column Data Loader

This block is the logic core of a 160-column display driver. Pixel data arrive on a bus that is 4 or 8 bits wide, one group per falling edge of a shift clock. The groups collect in a line register. A falling edge of a data strobe then copies the whole line into the output latch, and the latch drives the column outputs. Several of these blocks can be chained. An active-low enable token tells a block when it may start taking groups. When a block has taken its last group, it passes the token on to the next block in the chain. The direction input picks the end of the row that loading starts from, and also swaps which of the two chain pins is the input and which is the output.

The shift clock and the strobe are sampled by a fast system clock, `clk`, and are acted on at their detected falling edges. The data bus and the mode inputs (`busWide`, `dirLeft`, `invData`) are sampled in the same `clk` cycle as the shift edge. The output control input can blank every column at any time. Blanking does not disturb the latched line.

Top module: `colDriverCore`

## Requirements
- R1: Each detected falling edge of `shiftClk` that the block accepts stores one group of bus bits into the line register. The line register is not visible on `colOut` until a strobe.
- R2: With `busWide`=1 a group is 8 bits (`dataIn[7:0]`) and a line is 20 groups. With `busWide`=0 a group is 4 bits (`dataIn[3:0]`) and a line is 40 groups.
- R3: With `busWide`=0, `dataIn[7:4]` has no effect on any stored bit.
- R4: Let w be the group width. With `dirLeft`=0, group g fills `colOut[g*w+k]` from bus bit k. With `dirLeft`=1, group g fills `colOut[160-(g+1)*w+k]` from bus bit k, so filling starts at `colOut[159]` and moves down.
- R5: With `invData`=1, every stored bit is the complement of its bus bit. With `invData`=0 it is stored unchanged.
- R6: `colOut` changes only on a detected falling edge of `dataStb`, which copies the line register into the output latch, or when `outCtl` changes.
- R7: While `outCtl`=1 all of `colOut` is 0. While `outCtl`=0, `colOut` shows the output latch.
- R8: With `dirLeft`=0, `chainAIn` is the enable input, `chainBOe`=1 and `chainAOe`=0. With `dirLeft`=1 the roles swap: `chainBIn` is the enable input, `chainAOe`=1 and `chainBOe`=0.
- R9: Before a line starts, shift edges are ignored unless the enable input is low at that edge. Once a line has started, the enable input is ignored until the next strobe.
- R10: The shift edge that stores the last group drives the enable output (`chainAOut`/`chainBOut`) low. The next shift edge drives it high again. Shift edges after the last group store nothing. At all other times the enable output is high.
- R11: A strobe edge returns the group counter to group 0 and waits for the enable input again. A shift edge in the same `clk` cycle as a strobe edge is ignored.
- R12: After reset, `colOut` is all zeros and both enable outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rstN | input | 1 | Active-low synchronous reset |
| shiftClk | input | 1 | Shift clock; acts on its falling edge |
| dataStb | input | 1 | Data strobe; falling edge moves the line into the output latch |
| dataIn | input | 8 | Pixel data bus |
| dirLeft | input | 1 | Fill direction and chain pin role select |
| outCtl | input | 1 | Forces all column outputs low when high |
| invData | input | 1 | Complements incoming data when high |
| busWide | input | 1 | 1 selects the 8-bit bus, 0 the 4-bit bus |
| chainAIn | input | 1 | Level on chain pin A when it is the enable input |
| chainAOut | output | 1 | Active-low enable value driven on chain pin A |
| chainAOe | output | 1 | Output enable for chain pin A |
| chainBIn | input | 1 | Level on chain pin B when it is the enable input |
| chainBOut | output | 1 | Active-low enable value driven on chain pin B |
| chainBOe | output | 1 | Output enable for chain pin B |
| colOut | output | 160 | Column output bits |

## Verification
The checker watches four things on every cycle: the blanking by `outCtl`, that `colOut` stays still unless a strobe edge or an `outCtl` change comes first, that the enable output only falls on a shift edge and only rises on a shift or strobe edge, and the state just after reset. The mapping from each group to its column positions has to be shown by the bench's full-line sweeps, and so do inversion, the ignored upper nibble, the gating by the enable token, the counter reset on a strobe and the swapping of the chain pin roles. The bench compares all 160 columns against a line it builds arithmetically.

// File: rtl/colDrvPkg.sv
package colDrvPkg;
  localparam int GRP_W = 6;  // holds group indices up to 63

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DONE
  } loadState_t;

  typedef struct packed {
    logic             load;  // store one group this cycle
    logic [GRP_W-1:0] grp;   // which group to store
    logic             xfer;  // copy line into output latch
  } ctlStrobe_t;
endpackage

// File: rtl/colDrvCtl.sv
module colDrvCtl
  import colDrvPkg::*;
#(
  parameter int NUM_OUT = 160,
  parameter int BUS_W   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       shiftClk,
  input  logic       dataStb,
  input  logic       busWide,
  input  logic       chainInN,
  output ctlStrobe_t stb,
  output logic       chainOutN
);
  localparam int WIDE_LAST   = NUM_OUT / BUS_W - 1;
  localparam int NARROW_LAST = NUM_OUT / (BUS_W / 2) - 1;

  logic             prevShift, prevStb;
  logic             shiftFall, stbFall;
  logic [GRP_W-1:0] grpCnt, lastGrp;
  logic             carry, atLast;
  loadState_t       state;

  assign shiftFall = prevShift & ~shiftClk;
  assign stbFall   = prevStb & ~dataStb;
  assign lastGrp   = busWide ? GRP_W'(WIDE_LAST) : GRP_W'(NARROW_LAST);

  always_comb begin
    stb.xfer = stbFall;
    stb.grp  = (state == ST_LOAD) ? grpCnt : '0;
    stb.load = shiftFall & ~stbFall &
               (((state == ST_IDLE) & ~chainInN) | (state == ST_LOAD));
    atLast   = (stb.grp >= lastGrp);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevShift <= 1'b0;
      prevStb   <= 1'b0;
      grpCnt    <= '0;
      carry     <= 1'b0;
      state     <= ST_IDLE;
    end else begin
      prevShift <= shiftClk;
      prevStb   <= dataStb;
      if (stbFall) begin
        grpCnt <= '0;
        carry  <= 1'b0;
        state  <= ST_IDLE;
      end else if (shiftFall) begin
        case (state)
          ST_IDLE: if (!chainInN) begin
            grpCnt <= GRP_W'(1);
            state  <= ST_LOAD;
          end
          ST_LOAD: if (atLast) begin
            grpCnt <= '0;
            carry  <= 1'b1;
            state  <= ST_DONE;
          end else begin
            grpCnt <= grpCnt + 1'b1;
          end
          default: carry <= 1'b0;
        endcase
      end
    end
  end

  assign chainOutN = ~carry;
endmodule

// File: rtl/colDrvPath.sv
module colDrvPath
  import colDrvPkg::*;
#(
  parameter int NUM_OUT = 160,
  parameter int BUS_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [BUS_W-1:0]   dataIn,
  input  logic               busWide,
  input  logic               dirLeft,
  input  logic               invData,
  input  logic               outCtl,
  output logic [NUM_OUT-1:0] colOut
);
  localparam int NW = BUS_W / 2;

  logic [NUM_OUT-1:0] lineReg;
  logic [NUM_OUT-1:0] outLatch;

  for (genvar i = 0; i < NUM_OUT; i++) begin : gBit
    localparam int G_WR = i / BUS_W;
    localparam int G_WL = (NUM_OUT - 1 - i) / BUS_W;
    localparam int G_NR = i / NW;
    localparam int G_NL = (NUM_OUT - 1 - i) / NW;
    localparam int K_W  = i % BUS_W;
    localparam int K_N  = i % NW;

    logic [GRP_W-1:0] myGrp;
    logic             srcBit;
    logic             bitQ;

    always_comb begin
      if (busWide) myGrp = dirLeft ? GRP_W'(G_WL) : GRP_W'(G_WR);
      else         myGrp = dirLeft ? GRP_W'(G_NL) : GRP_W'(G_NR);
      srcBit = (busWide ? dataIn[K_W] : dataIn[K_N]) ^ invData;
    end

    always_ff @(posedge clk) begin
      if (!rstN)                            bitQ <= 1'b0;
      else if (stb.load && stb.grp == myGrp) bitQ <= srcBit;
    end

    assign lineReg[i] = bitQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         outLatch <= '0;
    else if (stb.xfer) outLatch <= lineReg;
  end

  assign colOut = outCtl ? '0 : outLatch;
endmodule

// File: rtl/colDriverCore.sv
module colDriverCore
  import colDrvPkg::*;
#(
  parameter int NUM_OUT = 160,
  parameter int BUS_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               shiftClk,
  input  logic               dataStb,
  input  logic [BUS_W-1:0]   dataIn,
  input  logic               dirLeft,
  input  logic               outCtl,
  input  logic               invData,
  input  logic               busWide,
  input  logic               chainAIn,
  output logic               chainAOut,
  output logic               chainAOe,
  input  logic               chainBIn,
  output logic               chainBOut,
  output logic               chainBOe,
  output logic [NUM_OUT-1:0] colOut
);
  ctlStrobe_t stb;
  logic       enInN, enOutN;

  assign enInN     = dirLeft ? chainBIn : chainAIn;
  assign chainAOe  = dirLeft;
  assign chainBOe  = ~dirLeft;
  assign chainAOut = enOutN;
  assign chainBOut = enOutN;

  colDrvCtl #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W)) uCtl (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .dataStb(dataStb),
    .busWide(busWide), .chainInN(enInN), .stb(stb), .chainOutN(enOutN)
  );

  colDrvPath #(.NUM_OUT(NUM_OUT), .BUS_W(BUS_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .dataIn(dataIn), .busWide(busWide),
    .dirLeft(dirLeft), .invData(invData), .outCtl(outCtl), .colOut(colOut)
  );
endmodule

// File: rtl/colDrvChecker.sv
module colDrvChecker #(
  parameter int NUM_OUT = 160
) (
  input logic               clk,
  input logic               rstN,
  input logic               shiftClk,
  input logic               dataStb,
  input logic               outCtl,
  input logic               chainBOut,
  input logic [NUM_OUT-1:0] colOut
);
  logic prevShiftChk, prevStbChk;
  logic shiftFallChk, stbFallChk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevShiftChk <= 1'b0;
      prevStbChk   <= 1'b0;
    end else begin
      prevShiftChk <= shiftClk;
      prevStbChk   <= dataStb;
    end
  end

  assign shiftFallChk = prevShiftChk & ~shiftClk;
  assign stbFallChk   = prevStbChk & ~dataStb;

  AST_BLANK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    outCtl |-> (colOut == '0)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(stbFallChk) && $stable(outCtl)) |-> $stable(colOut)); // R6

  AST_TOKEN_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chainBOut) |-> $past(shiftFallChk)); // R10

  AST_TOKEN_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chainBOut) |-> $past(shiftFallChk || stbFallChk)); // R10

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> ((colOut == '0) && chainBOut)); // R12
endmodule

bind colDriverCore colDrvChecker #(.NUM_OUT(NUM_OUT)) uChk (
  .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .dataStb(dataStb),
  .outCtl(outCtl), .chainBOut(chainBOut), .colOut(colOut)
);

// File: tb/sim_colDriverCore.sv
`timescale 1ns/1ps
module sim_colDriverCore;
  localparam int N = 160;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         shiftClk = 1'b1, dataStb = 1'b1;
  logic [7:0]   dataIn = '0;
  logic         dirLeft = 1'b0, outCtl = 1'b0, invData = 1'b0, busWide = 1'b1;
  logic         chainAIn = 1'b1, chainBIn = 1'b1;
  logic         chainAOut, chainAOe, chainBOut, chainBOe;
  logic [N-1:0] colOut;

  logic [N-1:0] expLine = '0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;  // 125 MHz

  colDriverCore u0 (
    .clk(clk), .rstN(rstN), .shiftClk(shiftClk), .dataStb(dataStb),
    .dataIn(dataIn), .dirLeft(dirLeft), .outCtl(outCtl), .invData(invData),
    .busWide(busWide), .chainAIn(chainAIn), .chainAOut(chainAOut),
    .chainAOe(chainAOe), .chainBIn(chainBIn), .chainBOut(chainBOut),
    .chainBOe(chainBOe), .colOut(colOut)
  );

  task automatic chkVec(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s colOut act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chkBit(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  task automatic shiftPulse(logic [7:0] d);
    @(negedge clk); shiftClk = 1'b0; dataIn = d;
    @(negedge clk); shiftClk = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobePulse();
    @(negedge clk); dataStb = 1'b0;
    @(negedge clk); dataStb = 1'b1;
    @(negedge clk);
  endtask

  // Expected placement from the requirement formulas (R4, R5, R2, R3)
  task automatic modelGroup(int g, logic [7:0] d);
    int w = busWide ? 8 : 4;
    for (int k = 0; k < w; k++) begin
      int pos = dirLeft ? (N - (g + 1) * w + k) : (g * w + k);
      expLine[pos] = d[k] ^ invData;
    end
  endtask

  function automatic logic [7:0] pat(int g, int seed);
    return 8'((g * seed + 11) & 255);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=expired exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    chkVec("R12", colOut, '0);
    chkBit("R12", "chainAOut", chainAOut, 1'b1);
    chkBit("R12", "chainBOut", chainBOut, 1'b1);
    // R8 roles, dirLeft=0
    chkBit("R8", "chainAOe", chainAOe, 1'b0);
    chkBit("R8", "chainBOe", chainBOe, 1'b1);

    // R9: enable high, shift edges ignored
    for (int g = 0; g < 3; g++) shiftPulse(8'hFF);
    strobePulse();
    chkVec("R9", colOut, '0);

    // R1 R2 R4: 8-bit, fill upward
    chainAIn = 1'b0;
    for (int g = 0; g < 20; g++) begin
      shiftPulse(pat(g, 37));
      modelGroup(g, pat(g, 37));
      if (g == 0) chainAIn = 1'b1;  // R9: enable ignored once started
    end
    chkVec("R1", colOut, '0);
    chkBit("R10", "enable out after last", chainBOut, 1'b0);
    shiftPulse(8'h5A);  // R10: beyond last, stored nowhere
    chkBit("R10", "enable out released", chainBOut, 1'b1);
    shiftPulse(8'hA5);
    chkBit("R10", "enable out stays high", chainBOut, 1'b1);
    strobePulse();
    chkVec("R4", colOut, expLine);

    // R7 blanking
    @(negedge clk); outCtl = 1'b1;
    @(negedge clk); chkVec("R7", colOut, '0);
    outCtl = 1'b0;
    @(negedge clk); chkVec("R7", colOut, expLine);

    // R2 R3 R4 R5 R8: 4-bit, fill downward, inverted, chain pin B in
    dirLeft = 1'b1; busWide = 1'b0; invData = 1'b1;
    @(negedge clk);
    chkBit("R8", "chainAOe", chainAOe, 1'b1);
    chkBit("R8", "chainBOe", chainBOe, 1'b0);
    chainAIn = 1'b0;  // not the input now: must not start a line
    shiftPulse(8'h0F);
    strobePulse();
    chkVec("R8", colOut, expLine);
    chainAIn = 1'b1; chainBIn = 1'b0;
    for (int g = 0; g < 40; g++) begin
      logic [7:0] d = pat(g, 29) | 8'hA0;  // upper nibble noise, R3
      shiftPulse(d);
      modelGroup(g, d);
      if (g < 39) chkBit("R2", "enable out mid-line", chainAOut, 1'b1);
    end
    chkBit("R10", "enable out after 40th", chainAOut, 1'b0);
    chainBIn = 1'b1;
    strobePulse();
    chkVec("R3", colOut, expLine);
    chkVec("R5", colOut, expLine);

    // R11: strobe mid-line, then restart at group 0
    dirLeft = 1'b0; busWide = 1'b1; invData = 1'b0; chainAIn = 1'b0;
    for (int g = 0; g < 5; g++) begin
      shiftPulse(pat(g, 53));
      modelGroup(g, pat(g, 53));
    end
    strobePulse();
    chkVec("R11", colOut, expLine);
    // strobe and shift in the same cycle: shift ignored
    @(negedge clk); dataStb = 1'b0; shiftClk = 1'b0; dataIn = 8'hC3;
    @(negedge clk); dataStb = 1'b1; shiftClk = 1'b1;
    @(negedge clk);
    shiftPulse(8'h96);
    modelGroup(0, 8'h96);
    strobePulse();
    chkVec("R11", colOut, expLine);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule